// File: doc/BRIEF.md
# Write-Back Block Cache Controller

This block sits between a processor and a slower word-wide memory and keeps copies of recently used 16-word blocks. Addresses are 16-bit word addresses. The store holds 128 blocks. The `WAYS` parameter selects the organisation. With `WAYS = 1` the cache is direct-mapped: it has a 7-bit line index and a 5-bit tag. With `WAYS = 2` (the default) it is two-way set-associative: it has 64 sets, a 6-bit set index and a 6-bit tag, and both ways of a set are compared in the same cycle. Writes stay in the cache and mark the block dirty. A dirty block is copied back to memory in full before its line is reused.

On a read miss the controller fetches the block one word at a time, starting at word 0. It hands the requested word to the processor in the cycle after that word arrives, and the rest of the block keeps filling in the background. On a write miss the controller fetches the block first and then updates the addressed word.

Two further commands are available. An invalidate command drops the resident copy of a block that another agent has rewritten in memory. A flush command copies every dirty block back to memory. In the idle state a flush request is taken first, then an invalidate request, then a processor request. Each request is held high until its done pulse.

Top module: `cachewb_top`

## Requirements
- R1: After reset `cpu_done`, `inv_done`, `flush_done` and `mem_req` are low and no block is valid, so the first access to any address misses.
- R2: In the default two-way build, `addr[3:0]` selects the word, `addr[9:4]` selects the set and `addr[15:10]` is the tag. Two blocks with the same set field and different tags can be resident together, and both then hit.
- R3: A read hit pulses `cpu_done` one cycle after the request is taken, with the cached word on `cpu_rdata` and no memory transfer.
- R4: A write hit updates only the cached word, marks the block dirty and pulses `cpu_done` one cycle after the request, with no memory transfer.
- R5: A read miss fetches all 16 words of the block in order from word 0. `cpu_done` pulses, with the requested word, in the cycle after word `addr[3:0]` is accepted. With memory acknowledging every cycle this is 2+`addr[3:0]` cycles after the request.
- R6: A write miss fetches the whole block and then overwrites the addressed word. Its `cpu_done` pulses after the last word, 17 cycles after the request when the victim is clean, and the block is left dirty.
- R7: When the chosen victim is valid and dirty, all 16 of its words are written to memory (`mem_we` high) before the fill begins. This adds 16 cycles to the miss. A clean victim causes no memory writes.
- R8: The victim way in a set is an invalid way if one exists, with way 0 taken first. Otherwise it is the way that was not accessed most recently.
- R9: An invalidate request is done in one cycle (`inv_done` pulses on the next cycle). It clears the valid bit of the block holding `inv_addr`, so the next access to that block misses. If the block is not resident, the cache contents are unchanged.
- R10: A flush writes every valid dirty block back to memory and clears its dirty bit while leaving it valid, then pulses `flush_done`. A second flush with no writes in between performs no memory writes.
- R11: Each memory word transfer completes only on a cycle with `mem_ack` high. Until that cycle, `mem_req`, `mem_we` and `mem_addr` hold their values. `mem_addr` is {tag, set, word counter}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 16 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| inv_req | input | 1 | Invalidate request, held until `inv_done` |
| inv_addr | input | 16 | Any word address inside the block to drop |
| inv_done | output | 1 | One-cycle completion pulse for invalidate |
| flush_req | input | 1 | Flush request, held until `flush_done` |
| flush_done | output | 1 | One-cycle completion pulse for flush |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 for a write-back word, 0 for a fill word |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_rdata | input | 16 | Fill data, valid with `mem_ack` |
| mem_ack | input | 1 | Word transfer accepted this cycle |

## Verification
The bench measures each processor result in whole cycles from the edge that takes the request. A hit finishes in 1 cycle, a clean read miss in 2 plus the word offset, and a clean write miss in 17. A dirty victim adds 16 to either kind of miss. The bench samples `cpu_done` on every falling edge and compares the count with these figures. Memory traffic is counted only after `mem_req` has dropped, so load-through does not cut a fill count short. Invalidate completion is checked on the first falling edge after the request, and a randomised sweep with acknowledge stalls checks every returned word and the final memory image.

// File: rtl/cachewb_pkg.sv
package cachewb_pkg;
  localparam int ADDR_W = 16;
  localparam int OFF_W  = 4;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2,
    ST_SCAN  = 2'd3
  } cst_e;
endpackage

// File: rtl/cachewb_data.sv
module cachewb_data #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/cachewb_dir.sv
module cachewb_dir #(
  parameter int WAYS   = 2,
  parameter int SETS   = 64,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 6,
  parameter int LINE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_set,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic              hit_way,
  output logic              vic_way,
  output logic              vic_valid,
  output logic              vic_dirty,
  output logic [TAG_W-1:0]  vic_tag,
  input  logic [LINE_W-1:0] q_line,
  output logic              q_valid,
  output logic              q_dirty,
  output logic [TAG_W-1:0]  q_tag,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              tch_en,
  input  logic [IDX_W-1:0]  tch_set,
  input  logic              tch_way,
  output logic              any_dirty
);
  localparam int NLINES = 1 << LINE_W;

  logic [TAG_W-1:0]  tags [NLINES];
  logic [NLINES-1:0] vld, drt;
  logic [SETS-1:0]   lru;

  logic [WAYS-1:0]  hit_oh, way_v, way_d;
  logic [TAG_W-1:0] way_t [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] lw;
    assign lw        = LINE_W'(w) * LINE_W'(SETS) + LINE_W'(lk_set);
    assign way_v[w]  = vld[lw];
    assign way_d[w]  = drt[lw];
    assign way_t[w]  = tags[lw];
    assign hit_oh[w] = vld[lw] && (tags[lw] == lk_tag);
  end

  assign hit     = |hit_oh;
  assign hit_way = (WAYS > 1) && hit_oh[WAYS-1];

  if (WAYS > 1) begin : g_pick2
    assign vic_way = !way_v[0] ? 1'b0 : (!way_v[WAYS-1] ? 1'b1 : lru[lk_set]);
  end else begin : g_pick1
    assign vic_way = 1'b0;
  end

  assign vic_valid = vic_way ? way_v[WAYS-1] : way_v[0];
  assign vic_dirty = vic_way ? way_d[WAYS-1] : way_d[0];
  assign vic_tag   = vic_way ? way_t[WAYS-1] : way_t[0];

  assign q_valid   = vld[q_line];
  assign q_dirty   = drt[q_line];
  assign q_tag     = tags[q_line];
  assign any_dirty = |(vld & drt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      drt <= '0;
      lru <= '0;
    end else begin
      if (wr_en) begin
        vld[wr_line] <= wr_valid;
        drt[wr_line] <= wr_dirty;
      end
      if (tch_en) lru[tch_set] <= ~tch_way;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tags[wr_line] <= wr_tag;
  end

  // R2: a tag never matches in two ways of one set
  p_hit_unique_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_oh));

  // R9: a line written invalid reads back invalid on the next cycle
  p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_valid |=> !vld[$past(wr_line)]);
endmodule

// File: rtl/cachewb_top.sv
module cachewb_top
  import cachewb_pkg::*;
#(
  parameter int NUM_BLOCKS = 128,
  parameter int WAYS       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  input  logic              inv_req,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              inv_done,
  input  logic              flush_req,
  output logic              flush_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int SETS   = NUM_BLOCKS / WAYS;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int LINE_W = $clog2(NUM_BLOCKS);
  localparam int DA_W   = LINE_W + OFF_W;

  function automatic logic [IDX_W-1:0] f_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [LINE_W-1:0] f_line(input logic way, input logic [IDX_W-1:0] s);
    return (LINE_W'(way) << IDX_W) | LINE_W'(s);
  endfunction
  function automatic logic [IDX_W-1:0] f_sol(input logic [LINE_W-1:0] l);
    return l[IDX_W-1:0];
  endfunction
  function automatic logic f_wol(input logic [LINE_W-1:0] l);
    return (WAYS > 1) && l[LINE_W-1];
  endfunction

  cst_e              state;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_we;
  logic [DATA_W-1:0] lat_wdata;
  logic [LINE_W-1:0] vline, scan;
  logic [TAG_W-1:0]  vtag;
  logic [OFF_W-1:0]  cnt;
  logic              wb_flush;

  // request selection in idle: flush, then invalidate, then processor
  logic idle, take_flush, take_inv, take_cpu;
  logic [ADDR_W-1:0] lk_addr;
  assign idle       = (state == ST_IDLE);
  assign take_flush = idle && flush_req;
  assign take_inv   = idle && !flush_req && inv_req;
  assign take_cpu   = idle && !flush_req && !inv_req && cpu_req;
  assign lk_addr    = take_inv ? inv_addr : cpu_addr;

  logic             hit, hit_way, vic_way, vic_valid, vic_dirty;
  logic [TAG_W-1:0] vic_tag, q_tag;
  logic             q_valid, q_dirty, any_dirty;
  logic              dir_we, dir_v, dir_d, tch_en, tch_way;
  logic [LINE_W-1:0] dir_line, hit_line;
  logic [TAG_W-1:0]  dir_tag;
  logic [IDX_W-1:0]  tch_set;

  // named events
  logic ev_hit, ev_miss, ev_word, ev_last;
  assign ev_hit   = take_cpu && hit;
  assign ev_miss  = take_cpu && !hit;
  assign ev_word  = mem_req && mem_ack;
  assign ev_last  = ev_word && (cnt == '1);
  assign hit_line = f_line(hit_way, f_set(lk_addr));

  cachewb_dir #(.WAYS(WAYS), .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W),
                .LINE_W(LINE_W)) u_dir (
    .clk, .rst_n,
    .lk_set(f_set(lk_addr)), .lk_tag(f_tag(lk_addr)),
    .hit, .hit_way, .vic_way, .vic_valid, .vic_dirty, .vic_tag,
    .q_line(scan), .q_valid, .q_dirty, .q_tag,
    .wr_en(dir_we), .wr_line(dir_line), .wr_valid(dir_v), .wr_dirty(dir_d),
    .wr_tag(dir_tag),
    .tch_en, .tch_set, .tch_way, .any_dirty
  );

  always_comb begin
    dir_we = 1'b0; dir_line = hit_line; dir_v = 1'b1; dir_d = 1'b0;
    dir_tag = f_tag(lk_addr);
    tch_en = 1'b0; tch_set = f_set(lk_addr); tch_way = hit_way;
    if (take_inv && hit) begin
      dir_we = 1'b1; dir_v = 1'b0;
    end else if (ev_hit) begin
      tch_en = 1'b1;
      if (cpu_we) begin dir_we = 1'b1; dir_d = 1'b1; end
    end else if (state == ST_WBACK && ev_last) begin
      dir_we = 1'b1; dir_line = vline; dir_tag = vtag;
    end else if (state == ST_FILL && ev_last) begin
      dir_we = 1'b1; dir_line = vline; dir_d = lat_we; dir_tag = f_tag(lat_addr);
      tch_en = 1'b1; tch_set = f_sol(vline); tch_way = f_wol(vline);
    end
  end

  logic            d_we;
  logic [DA_W-1:0] d_waddr, d_raddr;
  logic [DATA_W-1:0] d_wdata, d_rdata;

  always_comb begin
    d_raddr = idle ? {hit_line, f_off(cpu_addr)} : {vline, cnt};
    d_we    = 1'b0;
    d_waddr = {hit_line, f_off(cpu_addr)};
    d_wdata = cpu_wdata;
    if (ev_hit && cpu_we) begin
      d_we = 1'b1;
    end else if (state == ST_FILL && ev_word) begin
      d_we    = 1'b1;
      d_waddr = {vline, cnt};
      d_wdata = (lat_we && cnt == f_off(lat_addr)) ? lat_wdata : mem_rdata;
    end
  end

  cachewb_data #(.AW(DA_W), .DW(DATA_W)) u_data (
    .clk, .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(d_raddr), .rdata(d_rdata)
  );

  assign mem_req   = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = mem_we ? {vtag, f_sol(vline), cnt}
                            : {f_tag(lat_addr), f_set(lat_addr), cnt};
  assign mem_wdata = d_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; lat_addr <= '0; lat_we <= 1'b0; lat_wdata <= '0;
      vline <= '0; vtag <= '0; cnt <= '0; wb_flush <= 1'b0; scan <= '0;
      cpu_done <= 1'b0; cpu_rdata <= '0; inv_done <= 1'b0; flush_done <= 1'b0;
    end else begin
      cpu_done <= 1'b0; inv_done <= 1'b0; flush_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take_flush) begin
            scan <= '0; state <= ST_SCAN;
          end else if (take_inv) begin
            inv_done <= 1'b1;
          end else if (ev_hit) begin
            if (!cpu_we) cpu_rdata <= d_rdata;
            cpu_done <= 1'b1;
          end else if (ev_miss) begin
            lat_addr <= cpu_addr; lat_we <= cpu_we; lat_wdata <= cpu_wdata;
            vline <= f_line(vic_way, f_set(cpu_addr)); vtag <= vic_tag;
            cnt <= '0; wb_flush <= 1'b0;
            state <= (vic_valid && vic_dirty) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: if (ev_word) begin
          cnt <= cnt + 1'b1;
          if (ev_last) state <= wb_flush ? ST_SCAN : ST_FILL;
        end
        ST_FILL: if (ev_word) begin
          cnt <= cnt + 1'b1;
          if (!lat_we && cnt == f_off(lat_addr)) begin
            cpu_rdata <= mem_rdata; cpu_done <= 1'b1;
          end
          if (ev_last) begin
            if (lat_we) cpu_done <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_SCAN: begin
          if (q_valid && q_dirty) begin
            vline <= scan; vtag <= q_tag; cnt <= '0; wb_flush <= 1'b1;
            state <= ST_WBACK;
          end else if (scan == '1) begin
            flush_done <= 1'b1; state <= ST_IDLE;
          end else begin
            scan <= scan + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: an unacknowledged transfer keeps its request, direction and address
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R5: a load-through completion carries the word that just arrived
  p_loadthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done && $past(state == ST_FILL) && !$past(lat_we)
      |-> cpu_rdata == $past(mem_rdata));

  // R10: no dirty valid block remains when a flush completes
  p_flush_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !any_dirty);

  // R7: the processor is not released while a victim is being copied out
  p_no_done_in_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WBACK |-> !cpu_done);
endmodule

// File: tb/sim_cachewb_top.sv
`timescale 1ns/1ps
module sim_cachewb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, inv_req = 0, flush_req = 0, mem_ack = 0;
  logic [15:0] cpu_addr = 0, cpu_wdata = 0, inv_addr = 0, mem_rdata = 0;
  logic [15:0] cpu_rdata, mem_addr, mem_wdata;
  logic cpu_done, inv_done, flush_done, mem_req, mem_we;

  cachewb_top u0 (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata,
    .cpu_done, .inv_req, .inv_addr, .inv_done, .flush_req, .flush_done,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .mem_ack
  );

  int n_chk = 0, n_err = 0, rd_cnt = 0, wr_cnt = 0, tick = 0;
  bit stall_en = 0, reported = 0;
  logic [15:0] mm   [logic [15:0]];
  logic [15:0] gold [logic [15:0]];

  function automatic logic [15:0] finit(logic [15:0] a);
    return (a * 16'd40503) ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] mem_get(logic [15:0] a);
    return mm.exists(a) ? mm[a] : finit(a);
  endfunction
  function automatic logic [15:0] gold_get(logic [15:0] a);
    return gold.exists(a) ? gold[a] : finit(a);
  endfunction

  // memory model: decides the acknowledge for the coming edge
  always @(negedge clk) begin
    tick++;
    if (mem_req && !(stall_en && (tick % 3 == 0))) begin
      mem_ack = 1'b1;
      if (mem_we) begin mm[mem_addr] = mem_wdata; wr_cnt++; end
      else begin mem_rdata = mem_get(mem_addr); rd_cnt++; end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  task automatic op(input bit we, input logic [15:0] a, input logic [15:0] wd,
                    output logic [15:0] rd, output int lat, output int drd,
                    output int dwr);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_req = 1'b1; lat = 0;
    do begin
      @(posedge clk); @(negedge clk); lat++;
    end while (!cpu_done && lat < 5000);
    rd = cpu_rdata; cpu_req = 1'b0;
    while (mem_req) @(negedge clk);
    drd = rd_cnt - r0; dwr = wr_cnt - w0;
    if (we) gold[a] = wd;
  endtask

  task automatic acc(input bit we, input logic [15:0] a, input logic [15:0] wd,
                     input int e_lat, input int e_rd, input int e_wr,
                     input string tag);
    logic [15:0] rd; int lat, drd, dwr;
    op(we, a, wd, rd, lat, drd, dwr);
    chk(lat == e_lat, {tag, " latency"}, lat, e_lat);
    chk(drd == e_rd && dwr == e_wr, {tag, " memory reads/writes"},
        {drd[15:0], dwr[15:0]}, {e_rd[15:0], e_wr[15:0]});
    if (!we) chk(rd == gold_get(a), {tag, " data"}, rd, gold_get(a));
  endtask

  task automatic inval(input logic [15:0] a, input string tag);
    inv_addr = a; inv_req = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(inv_done == 1'b1, {tag, " inv_done after one cycle"}, inv_done, 1);
    inv_req = 1'b0;
  endtask

  task automatic flush(output int dwr);
    int w0, n;
    w0 = wr_cnt; n = 0; flush_req = 1'b1;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (!flush_done && n < 5000);
    flush_req = 1'b0;
    chk(flush_done == 1'b1, "R10 flush_done seen", flush_done, 1);
    dwr = wr_cnt - w0;
  endtask

  initial begin
    #(750_000ns);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    int fw;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!cpu_done && !inv_done && !flush_done && !mem_req, "R1 outputs in reset",
        {cpu_done, inv_done, flush_done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_done && !mem_req, "R1 idle after reset", {cpu_done, mem_req}, 0);

    acc(0, 16'h1235, 0, 7, 16, 0, "R1 R5 first read misses, load-through");
    acc(0, 16'h1230, 0, 1, 0, 0, "R3 read hit");
    acc(1, 16'h1231, 16'hBEEF, 1, 0, 0, "R4 write hit");
    acc(0, 16'h1231, 0, 1, 0, 0, "R4 read back written word");
    acc(0, 16'h5632, 0, 4, 16, 0, "R8 invalid way used");
    acc(0, 16'h1233, 0, 1, 0, 0, "R2 both tags resident");
    acc(0, 16'h9A34, 0, 6, 16, 0, "R8 LRU way replaced");
    acc(0, 16'h1231, 0, 1, 0, 0, "R8 recent dirty block kept");
    acc(0, 16'h5630, 0, 2, 16, 0, "R8 LRU clean victim");
    acc(0, 16'h9A34, 0, 22, 16, 16, "R7 dirty victim written back");
    chk(mem_get(16'h1231) == 16'hBEEF, "R7 written-back word in memory",
        mem_get(16'h1231), 16'hBEEF);
    acc(1, 16'h2005, 16'h1111, 17, 16, 0, "R6 write miss");
    acc(0, 16'h2005, 0, 1, 0, 0, "R6 merged word hits");
    acc(0, 16'h2006, 0, 1, 0, 0, "R6 rest of block filled");
    for (int w = 0; w < 16; w++)
      acc(0, 16'h9A30 + 16'(w), 0, 1, 0, 0, "R3 sweep of resident block");

    mm[16'h5637] = 16'h7777; gold[16'h5637] = 16'h7777;
    inval(16'h5637, "R9");
    acc(0, 16'h5637, 0, 9, 16, 0, "R9 invalidated block refetched");
    inval(16'h7770, "R9");
    acc(0, 16'h9A34, 0, 1, 0, 0, "R9 absent block leaves cache unchanged");

    flush(fw);
    chk(fw == 16, "R10 flush writes one dirty block", fw, 16);
    chk(mem_get(16'h2005) == 16'h1111, "R10 flushed word in memory",
        mem_get(16'h2005), 16'h1111);
    flush(fw);
    chk(fw == 0, "R10 second flush writes nothing", fw, 0);
    acc(0, 16'h2005, 0, 1, 0, 0, "R10 flushed block stays valid");
    acc(0, 16'h0400, 0, 2, 16, 0, "R8 second way of set 0");
    acc(0, 16'h0800, 0, 2, 16, 0, "R10 flushed victim is clean");

    // R11: randomised sweep with acknowledge stalls
    stall_en = 1; lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, rd;
      int lat, drd, dwr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {lfsr[15:13], 7'b0, lfsr[5:0]};
      if (i % 50 == 49) begin
        flush(fw);
        mm[a] = lfsr ^ 16'h0F0F; gold[a] = lfsr ^ 16'h0F0F;
        inval(a, "R9 sweep");
      end
      op(lfsr[7], a, lfsr ^ 16'(i), rd, lat, drd, dwr);
      if (!lfsr[7])
        chk(rd == gold_get(a), "R11 R3 sweep read data", rd, gold_get(a));
    end
    stall_en = 0;
    flush(fw);
    begin
      int bad = 0;
      for (int t = 0; t < 8; t++)
        for (int l = 0; l < 64; l++) begin
          logic [15:0] a;
          a = {3'(t), 7'b0, 6'(l)};
          if (mem_get(a) != gold_get(a)) bad++;
        end
      chk(bad == 0, "R10 R11 memory image after final flush", bad, 0);
    end
    report();
  end
endmodule